// File: doc/BRIEF.md
# Transmit Deferral and Retry Controller

This block sits in front of the byte serializer of a half-duplex Ethernet transmitter and decides when a pending frame may go onto the wire. It watches carrier sense against a bit-time tick and holds off until the medium has been quiet for the interframe gap. That gap has two parts: a quiet window that restarts whenever carrier returns, then a hold window during which carrier is no longer watched.

When a collision is reported during a frame, the block aborts the attempt and waits a random number of slot times. The range of that wait doubles with each collision, up to a cap. It then defers again and retries, until the number of collisions exceeds a programmable limit. Bytes pass from an upstream valid/ready source to the serializer. The first bytes of every frame are captured in a local buffer. On a retry, the block replays them from that buffer and the source stays paused, so the source never has to rewind. A graceful-stop input blocks new frames and never cuts a frame that is already on the wire.

Top module: `tx_defer_retry`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_start_o`, `tx_abort_o`, `retry_fail_o`, `txd_valid_o` and `src_ready_o` are 0. `stopped_o` is 0 while `gstop_i` is 0.
- R2: With `bit_tick_i` high every cycle, a pending frame sees `tx_start_o` pulse for one cycle 96 to 98 cycles after carrier sense falls. The gap is 60 quiet bit times followed by 36 more.
- R3: If carrier sense rises during the 60-bit quiet window, the gap restarts, so the start comes 96 to 98 cycles after the last fall of carrier sense.
- R4: If carrier sense rises during the final 36 bit times, it is ignored, so the start still comes 96 to 98 cycles after the earlier fall.
- R5: A collision (`col_i` high in a transmit cycle) produces a one-cycle `tx_abort_o` in the next cycle. After the nth collision, the retry start follows after k slot times of 512 bit times plus deferral. k is pseudo-random in 0 to 2^min(n,10)-1, so the abort-to-start distance lies between 90 and (2^n-1)*512+110 cycles.
- R6: If the collision count of a frame exceeds `retry_limit_i`, `retry_fail_o` pulses together with `tx_abort_o` and the frame is dropped without another start. A frame that ends with `tx_done_i` or with a failure clears the count for the next frame.
- R7: On a retry, the bytes already delivered in earlier attempts (up to 64) are replayed from the local buffer in their original order, with `src_ready_o` held at 0. The source then resumes from its first undelivered byte.
- R8: While `gstop_i` is 1 and no frame is being transmitted, `stopped_o` is 1 and no `tx_start_o` occurs.
- R9: Raising `gstop_i` during a frame leaves `stopped_o` at 0 and lets bytes continue to flow. Once the frame ends by `tx_done_i` or by collision, `stopped_o` rises and no retry or new frame starts.
- R10: When `gstop_i` falls with a frame pending and the gap already complete, `tx_start_o` pulses 1 to 2 cycles later.
- R11: On a first attempt, each byte accepted from the source appears unchanged and in order on `txd_data_o`. The source is accepted only when the serializer is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision detected |
| frame_req_i | input | 1 | Frame pending, held until done or failed |
| gstop_i | input | 1 | Graceful stop request |
| retry_limit_i | input | RETRY_W | Collisions allowed before the frame is dropped |
| tx_done_i | input | 1 | Serializer finished the frame normally |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Source byte accepted |
| txd_valid_o | output | 1 | Byte to serializer valid |
| txd_data_o | output | 8 | Byte to serializer |
| txd_ready_i | input | 1 | Serializer takes the byte |
| tx_start_o | output | 1 | One-cycle start of an attempt |
| tx_abort_o | output | 1 | One-cycle abort after a collision |
| retry_fail_o | output | 1 | One-cycle retry-limit failure |
| stopped_o | output | 1 | Graceful stop in effect |

## Verification
The gap is tried with three carrier patterns: a clean fall, a blip inside the quiet window and a blip inside the hold window. The start delay tells a restarting window from an ignored one. Frames meet zero, one and three collisions under limits that allow or refuse a retry. The retry's byte stream and the source's consumed count together tell a local replay from a refetch. Graceful stop is raised while idle, during a frame that completes and during a frame that collides, so blocking new work can be told apart from cutting a frame short.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_BACKOFF} tdr_state_e;
endpackage

// File: rtl/tdr_defer.sv
module tdr_defer #(
  parameter int QUIET_BITS = 60,
  parameter int HOLD_BITS  = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic crs_i,
  output logic gap_done_o
);
  localparam int GAP = QUIET_BITS + HOLD_BITS;
  localparam int CW  = $clog2(GAP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (clr_i)                          cnt_q <= '0;
    else if (crs_i && cnt_q < CW'(QUIET_BITS)) cnt_q <= '0;  // quiet window restarts
    else if (crs_i && cnt_q == CW'(GAP))     cnt_q <= '0;  // medium busy again after gap
    else if (tick_i && cnt_q < CW'(GAP))     cnt_q <= cnt_q + 1'b1;
  end

  assign gap_done_o = (cnt_q == CW'(GAP));
endmodule

// File: rtl/tdr_backoff.sv
module tdr_backoff #(
  parameter int SLOT_BITS = 512,
  parameter int CAP       = 10,
  parameter int NW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NW-1:0] coll_n_i,
  input  logic          tick_i,
  output logic          busy_o
);
  localparam int BW = $clog2(SLOT_BITS);

  logic [15:0]    lfsr_q;
  logic [CAP-1:0] mask, slots_q;
  logic [BW-1:0]  bitc_q;

  for (genvar i = 0; i < CAP; i++) begin : g_mask
    assign mask[i] = int'(coll_n_i) > i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= 16'hACE1;
    else         lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q <= '0;
      bitc_q  <= '0;
    end else if (load_i) begin
      slots_q <= lfsr_q[CAP-1:0] & mask;
      bitc_q  <= '0;
    end else if (tick_i && slots_q != '0) begin
      if (bitc_q == BW'(SLOT_BITS - 1)) begin
        bitc_q  <= '0;
        slots_q <= slots_q - 1'b1;
      end else begin
        bitc_q <= bitc_q + 1'b1;
      end
    end
  end

  assign busy_o = (slots_q != '0);
endmodule

// File: rtl/tdr_replay.sv
module tdr_replay #(
  parameter int DEPTH = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       frame_end_i,
  input  logic       active_i,
  input  logic       src_valid_i,
  input  logic [7:0] src_data_i,
  output logic       src_ready_o,
  output logic       txd_valid_o,
  output logic [7:0] txd_data_o,
  input  logic       txd_ready_i
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [AW:0] idx_q, stored_q;
  logic        from_buf, xfer, capture;

  assign from_buf    = idx_q < stored_q;
  assign txd_valid_o = active_i && (from_buf || src_valid_i);
  assign txd_data_o  = from_buf ? mem[idx_q[AW-1:0]] : src_data_i;
  assign src_ready_o = active_i && !from_buf && txd_ready_i;
  assign xfer        = txd_valid_o && txd_ready_i;
  assign capture     = xfer && !from_buf && idx_q < (AW+1)'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      stored_q <= '0;
    end else begin
      if (start_i)                                  idx_q <= '0;
      else if (xfer && idx_q < (AW+1)'(DEPTH))      idx_q <= idx_q + 1'b1;
      if (frame_end_i)                              stored_q <= '0;
      else if (capture)                             stored_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (capture) mem[idx_q[AW-1:0]] <= src_data_i;
  end
endmodule

// File: rtl/tx_defer_retry.sv
module tx_defer_retry
  import tdr_pkg::*;
#(
  parameter int QUIET_BITS   = 60,
  parameter int HOLD_BITS    = 36,
  parameter int SLOT_BITS    = 512,
  parameter int BACKOFF_CAP  = 10,
  parameter int REPLAY_BYTES = 64,
  parameter int RETRY_W      = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_tick_i,
  input  logic               crs_i,
  input  logic               col_i,
  input  logic               frame_req_i,
  input  logic               gstop_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  input  logic               tx_done_i,
  input  logic               src_valid_i,
  input  logic [7:0]         src_data_i,
  output logic               src_ready_o,
  output logic               txd_valid_o,
  output logic [7:0]         txd_data_o,
  input  logic               txd_ready_i,
  output logic               tx_start_o,
  output logic               tx_abort_o,
  output logic               retry_fail_o,
  output logic               stopped_o
);
  localparam int NW = RETRY_W + 1;

  tdr_state_e    state_q;
  logic [NW-1:0] coll_q, coll_next;
  logic          gap_done, bo_busy, go, hit, too_many, frame_end;

  assign go        = state_q == ST_IDLE && frame_req_i && !gstop_i && gap_done;
  assign hit       = state_q == ST_TX && col_i;
  assign coll_next = coll_q + 1'b1;
  assign too_many  = coll_next > {1'b0, retry_limit_i};
  assign frame_end = (state_q == ST_TX && !col_i && tx_done_i) || (hit && too_many);
  assign stopped_o = gstop_i && state_q != ST_TX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      coll_q       <= '0;
      tx_start_o   <= 1'b0;
      tx_abort_o   <= 1'b0;
      retry_fail_o <= 1'b0;
    end else begin
      tx_start_o   <= 1'b0;
      tx_abort_o   <= 1'b0;
      retry_fail_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q    <= ST_TX;
          tx_start_o <= 1'b1;
        end
        ST_TX: if (col_i) begin
          tx_abort_o <= 1'b1;
          if (too_many) begin
            retry_fail_o <= 1'b1;
            coll_q       <= '0;
            state_q      <= ST_IDLE;
          end else begin
            coll_q  <= coll_next;
            state_q <= ST_BACKOFF;
          end
        end else if (tx_done_i) begin
          coll_q  <= '0;
          state_q <= ST_IDLE;
        end
        ST_BACKOFF: if (!bo_busy) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  tdr_defer #(.QUIET_BITS(QUIET_BITS), .HOLD_BITS(HOLD_BITS)) u_defer (
    .clk_i, .rst_ni,
    .clr_i      (state_q == ST_TX),
    .tick_i     (bit_tick_i),
    .crs_i,
    .gap_done_o (gap_done)
  );

  tdr_backoff #(.SLOT_BITS(SLOT_BITS), .CAP(BACKOFF_CAP), .NW(NW)) u_backoff (
    .clk_i, .rst_ni,
    .load_i   (hit && !too_many),
    .coll_n_i (coll_next),
    .tick_i   (bit_tick_i),
    .busy_o   (bo_busy)
  );

  tdr_replay #(.DEPTH(REPLAY_BYTES)) u_replay (
    .clk_i, .rst_ni,
    .start_i     (go),
    .frame_end_i (frame_end),
    .active_i    (state_q == ST_TX),
    .src_valid_i,
    .src_data_i,
    .src_ready_o,
    .txd_valid_o,
    .txd_data_o,
    .txd_ready_i
  );
endmodule

// File: rtl/tdr_sva.sv
module tdr_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic col_i,
  input logic gstop_i,
  input logic txd_ready_i,
  input logic src_ready_o,
  input logic txd_valid_o,
  input logic tx_start_o,
  input logic tx_abort_o,
  input logic retry_fail_o,
  input logic stopped_o
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o); // R2
  AST_ABORT_FOLLOWS_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |-> $past(col_i)); // R5
  AST_FAIL_WITH_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_fail_o |-> tx_abort_o); // R6
  AST_NO_START_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |=> !tx_start_o); // R8
  AST_STOP_NEEDS_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> gstop_i); // R8
  AST_NO_DATA_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_valid_o |-> !stopped_o); // R9
  AST_SRC_PACED_BY_SINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> txd_ready_i && !stopped_o); // R11
endmodule

bind tx_defer_retry tdr_sva u_sva (.*);

// File: tb/sim_tx_defer_retry.sv
module sim_tx_defer_retry;
  logic       clk = 0, rst_ni = 0;
  logic       crs = 1, col = 0, frame_req = 0, gstop = 0, tx_done = 0;
  logic       src_valid = 0, txd_ready = 0;
  logic [3:0] retry_limit = 4'd15;
  logic [7:0] src_base = 0, src_data;
  logic       src_ready, txd_valid, tx_start, tx_abort, retry_fail, stopped;
  logic [7:0] txd_data;

  int nchk = 0, nfail = 0, cyc = 0, src_pos = 0, bytes_seen = 0;
  int nstart = 0, last_start = 0, last_abort = 0;
  int exp_ev[$]; string exp_evr[$];
  int exp_b[$];  string exp_br[$];

  always #10 clk = ~clk;
  assign src_data = src_base + src_pos[7:0];

  tx_defer_retry u0 (
    .clk_i(clk), .rst_ni, .bit_tick_i(1'b1), .crs_i(crs), .col_i(col),
    .frame_req_i(frame_req), .gstop_i(gstop), .retry_limit_i(retry_limit),
    .tx_done_i(tx_done), .src_valid_i(src_valid), .src_data_i(src_data),
    .src_ready_o(src_ready), .txd_valid_o(txd_valid), .txd_data_o(txd_data),
    .txd_ready_i(txd_ready), .tx_start_o(tx_start), .tx_abort_o(tx_abort),
    .retry_fail_o(retry_fail), .stopped_o(stopped)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic ev(input int code, input string req);
    exp_ev.push_back(code); exp_evr.push_back(req);
  endtask

  task automatic exp_bytes(input int base, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      exp_b.push_back((base + i) & 8'hFF); exp_br.push_back(req);
    end
  endtask

  task automatic see_ev(input int code);
    if (exp_ev.size() == 0) chk(0, "R8 unexpected event", code, 0);
    else begin
      int e; string r;
      e = exp_ev.pop_front(); r = exp_evr.pop_front();
      chk(e == code, r, code, e);
    end
  endtask

  initial forever begin
    @(posedge clk); cyc++;
  end

  // monitor: events and delivered bytes, sampled mid-cycle
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      if (tx_start)   begin see_ev(1); nstart++; last_start = cyc; end
      if (tx_abort)   begin see_ev(2); last_abort = cyc; end
      if (retry_fail) see_ev(3);
      if (txd_valid && txd_ready) begin
        bytes_seen++;
        if (exp_b.size() == 0) chk(0, "R11 unexpected byte", txd_data, 0);
        else begin
          int b; string r;
          b = exp_b.pop_front(); r = exp_br.pop_front();
          chk(int'(txd_data) == b, r, txd_data, b);
        end
      end
    end
  end

  // source model
  initial forever begin
    bit f;
    @(negedge clk); f = src_valid && src_ready;
    @(posedge clk); #1; if (f) src_pos++;
  end

  task automatic drv; @(posedge clk); #2; endtask

  task automatic wait_start;
    int n0 = nstart;
    while (nstart == n0) begin @(negedge clk); #1; end
  endtask

  task automatic send(input int n);
    int target;
    drv; txd_ready = 1; target = bytes_seen + n;
    while (bytes_seen < target) begin @(negedge clk); #1; end
    drv; txd_ready = 0;
  endtask

  task automatic collide; drv; col = 1; drv; col = 0; endtask

  task automatic finish_frame;
    drv; tx_done = 1; frame_req = 0; src_valid = 0;
    drv; tx_done = 0;
  endtask

  task automatic new_frame(input logic [7:0] base);
    drv; src_base = base; src_pos = 0; src_valid = 1; frame_req = 1;
  endtask

  task automatic idle(input int n); repeat (n) @(posedge clk); endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int c0, c1;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({tx_start, tx_abort, retry_fail, txd_valid, src_ready, stopped} == 0, "R1 in reset", 1, 0);
    drv; rst_ni = 1;
    @(negedge clk);
    chk({tx_start, tx_abort, retry_fail, txd_valid, src_ready, stopped} == 0, "R1 after reset", 1, 0);

    // R2 + R11: clean gap, pass-through
    new_frame(8'h10); ev(1, "R2 start");
    idle(5); drv; crs = 0; c0 = cyc;
    wait_start;
    chk(last_start - c0 >= 96 && last_start - c0 <= 98, "R2 gap length", last_start - c0, 97);
    exp_bytes(8'h10, 5, "R11 pass-through byte");
    send(5); finish_frame;
    chk(src_pos == 5, "R11 source consumed", src_pos, 5);

    // R3: carrier inside quiet window restarts
    drv; crs = 1; new_frame(8'h20); ev(1, "R3 start");
    drv; crs = 0; idle(30); drv; crs = 1; drv; crs = 0; c1 = cyc;
    wait_start;
    chk(last_start - c1 >= 96 && last_start - c1 <= 98, "R3 restarted gap", last_start - c1, 97);
    exp_bytes(8'h20, 3, "R11 pass-through byte"); send(3); finish_frame;

    // R4: carrier inside hold window ignored
    drv; crs = 1; new_frame(8'h30); ev(1, "R4 start");
    drv; crs = 0; c0 = cyc; idle(70); drv; crs = 1; drv; drv; crs = 0;
    wait_start;
    chk(last_start - c0 >= 96 && last_start - c0 <= 98, "R4 hold ignores carrier", last_start - c0, 97);
    exp_bytes(8'h30, 2, "R11 pass-through byte"); send(2); finish_frame;

    // R5 + R7: one collision, replay
    new_frame(8'h40); ev(1, "R5 first start"); wait_start;
    exp_bytes(8'h40, 8, "R11 first attempt byte"); send(8);
    ev(2, "R5 abort"); ev(1, "R5 retry start");
    collide; wait_start;
    chk(last_start - last_abort >= 90 && last_start - last_abort <= 622, "R5 backoff window n=1",
        last_start - last_abort, 622);
    exp_bytes(8'h40, 12, "R7 replayed/resumed byte"); send(12);
    chk(src_pos == 12, "R7 source not refetched", src_pos, 12);
    finish_frame;

    // R6: limit 2, third collision fails
    drv; retry_limit = 4'd2;
    new_frame(8'h60); ev(1, "R6 start 1"); wait_start;
    exp_bytes(8'h60, 2, "R7 byte"); send(2);
    ev(2, "R6 abort 1"); ev(1, "R6 start 2"); collide; wait_start;
    exp_bytes(8'h60, 2, "R7 byte"); send(2);
    ev(2, "R6 abort 2"); ev(1, "R6 start 3"); collide; wait_start;
    chk(last_start - last_abort >= 90 && last_start - last_abort <= 3*512+110, "R5 backoff window n=2",
        last_start - last_abort, 3*512+110);
    exp_bytes(8'h60, 2, "R7 byte"); send(2);
    ev(2, "R6 abort 3"); ev(3, "R6 limit fail"); collide;
    drv; frame_req = 0; src_valid = 0;
    idle(300);
    chk(exp_ev.size() == 0, "R6 frame dropped", exp_ev.size(), 0);
    chk(src_pos == 2, "R7 source held during replays", src_pos, 2);

    // R6: count cleared, limit 1 allows one retry
    drv; retry_limit = 4'd1;
    new_frame(8'h70); ev(1, "R6 new frame start"); wait_start;
    exp_bytes(8'h70, 1, "R11 byte"); send(1);
    ev(2, "R6 abort only"); ev(1, "R6 retry after clear"); collide; wait_start;
    exp_bytes(8'h70, 2, "R7 byte"); send(2); finish_frame;

    // R8 + R10: stop while idle
    drv; gstop = 1; new_frame(8'h80); idle(200);
    @(negedge clk);
    chk(stopped == 1, "R8 stopped in idle", stopped, 1);
    ev(1, "R10 resume start"); drv; gstop = 0; c0 = cyc;
    wait_start;
    chk(last_start - c0 >= 1 && last_start - c0 <= 2, "R10 resume delay", last_start - c0, 1);
    exp_bytes(8'h80, 2, "R11 byte"); send(2); finish_frame;

    // R9: stop during frame that completes
    new_frame(8'h90); ev(1, "R9 start"); wait_start;
    drv; gstop = 1;
    @(negedge clk);
    chk(stopped == 0, "R9 not stopped mid-frame", stopped, 0);
    exp_bytes(8'h90, 3, "R9 bytes flow under stop"); send(3);
    chk(src_pos == 3, "R9 frame continued", src_pos, 3);
    finish_frame;
    @(negedge clk);
    chk(stopped == 1, "R9 stopped after frame", stopped, 1);
    new_frame(8'hA0); idle(200);
    ev(1, "R10 resume start"); drv; gstop = 0; wait_start;

    // R9: stop during frame that collides
    drv; gstop = 1;
    exp_bytes(8'hA0, 2, "R9 byte"); send(2);
    ev(2, "R9 abort under stop"); collide;
    idle(800);
    @(negedge clk);
    chk(stopped == 1, "R9 halted after collision", stopped, 1);
    chk(exp_ev.size() == 0, "R9 no retry while stopped", exp_ev.size(), 0);
    ev(1, "R10 retry after release"); drv; gstop = 0; wait_start;
    exp_bytes(8'hA0, 3, "R7 byte"); send(3); finish_frame;

    idle(5);
    chk(exp_b.size() == 0, "R11 all bytes seen", exp_b.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule